// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a five-channel interval timer behind a simple word-wide register bus. Each channel counts down from a value software has placed in its count buffer. The rate of counting comes from one of two shared 8-bit prescalers, followed by a power-of-two divider that each channel selects for itself. A channel either runs once and stops, or reloads itself and runs periodically. Each expiry latches a pending bit. The channel's interrupt line is high while that bit and its enable are both set, and a write of 1 clears the bit.

Software fills a count buffer and a compare buffer, then sets the channel's manual-update bit. While that bit is set, both buffers are copied into the live counter and compare registers. Software then writes start, with or without auto-reload, in the same write that clears manual update. The live counter value can be read at any time. Each channel also gives a compare flag: it is high when the counter is at or below the compare value, and an invert bit flips it. The counter width is a parameter, 16 or 32 bits. With 16 bits, every divider select is raised by one power of two.

Top module: `ivt_timer`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `cmp_flag` is 5'b11111 (counter 0 is at or below compare 0).
- R2: Register offsets are: 0x00 prescalers (bits 15:0); 0x04 divider selects, 4 bits per channel n at bit 4n (bits 19:0); 0x08 control; 0x44 interrupt. For channel n, the count buffer is at 0x0C+12n and the compare buffer at 0x10+12n for n=0..3. The live counter reads at 0x14+12n for n=0..3 and at 0x40 for channel 4. Channel 4 has no compare buffer. Unused bits read 0, and writes to counter-observation offsets or to control bits 7:4 have no effect.
- R3: Each control nibble holds start (bit 0), manual update (bit 1), invert (bit 2) and auto-reload (bit 3). Channel 0 uses bits 3:0 and channel n≥1 uses bits 4(n+1)+3:4(n+1). While manual update is set, the counter and compare registers are loaded from the buffers every cycle and no counting takes place.
- R4: The prescaler in bits 7:0 drives channels 0 and 1, and the one in bits 15:8 drives channels 2 to 4. A channel ticks once every (P+1)·2^min(S+B,4) clocks, where P is its prescaler value, S its select and B is 0 for 32-bit counters and 1 for 16-bit counters.
- R5: With start set and auto-reload clear, a counter loaded with N≥1 expires on the N-th tick after the start write, goes to 0 and stays there. The hardware then clears start, unless a control write falls in that same cycle.
- R6: With auto-reload set, a channel expires every N ticks. On each expiry it reloads from its count buffer.
- R7: A counter loaded with 0 never expires and never raises a pending bit.
- R8: Clearing start holds the counter value. Setting start again resumes counting from the held value. Reads have no side effects.
- R9: In the interrupt register, channel n's enable is bit n and its pending bit is bit n+5. An expiry sets the pending bit whether or not the enable is set. Writing 1 to a pending bit clears it. `irq[n]` is high exactly while pending and enable are both set.
- R10: When an expiry and a write-1-clear of the same pending bit fall in the same cycle, the pending bit ends up set.
- R11: `cmp_flag[n]` is (counter ≤ compare) XOR invert. Channel 4 compares against 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 5 | Per-channel interrupt lines |
| cmp_flag | output | 5 | Per-channel compare flag |

## Verification
Two functions can land on the same clock edge. One is a channel expiry, which sets its pending bit. The other is a software write of 1 that clears that same bit. The bench counts forward from the edge on which it wrote start and schedules the interrupt-register write for exactly the expiry edge. It then reads the register back and expects the pending bit still set and the interrupt line high. Expected interrupt edges go into a scoreboard queue when start is written, and a monitor compares each rising `irq` against the channel and edge number at the front of that queue.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  localparam int unsigned NCH   = 5;
  localparam int unsigned NGRP  = 2;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned NIB   = 4;

  localparam int unsigned OFS_PSC  = 'h00;
  localparam int unsigned OFS_DSEL = 'h04;
  localparam int unsigned OFS_CTL  = 'h08;
  localparam int unsigned OFS_OBS4 = 'h40;
  localparam int unsigned OFS_INT  = 'h44;

  typedef struct packed {
    logic autorl;
    logic inv;
    logic manual;
    logic start;
  } ctl_t;

  function automatic int unsigned ofs_cntb(int unsigned n);
    return 'h0C + 12 * n;
  endfunction

  function automatic int unsigned ofs_cmpb(int unsigned n);
    return 'h10 + 12 * n;
  endfunction

  function automatic int unsigned ofs_obs(int unsigned n);
    return (n < NCH - 1) ? ('h14 + 12 * n) : OFS_OBS4;
  endfunction

  // nibble 1 is skipped: channel n>=1 sits in nibble n+1
  function automatic int unsigned ctl_lsb(int unsigned n);
    return (n == 0) ? 0 : NIB * (n + 1);
  endfunction

  function automatic int unsigned grp_of(int unsigned n);
    return (n < 2) ? 0 : 1;
  endfunction

endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
  parameter int unsigned PS_W      = 8,
  parameter int unsigned MAX_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PS_W-1:0]      div_val,
  output logic                 tick,
  output logic [MAX_SHIFT-1:0] phase
);

  logic [PS_W-1:0]      cnt_q;
  logic [PS_W-1:0]      cnt_n;
  logic [MAX_SHIFT-1:0] ph_n;

  always_comb begin
    tick  = (cnt_q >= div_val);
    cnt_n = tick ? '0 : cnt_q + 1'b1;
    ph_n  = tick ? phase + 1'b1 : phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= '0;
    end else begin
      cnt_q <= cnt_n;
      phase <= ph_n;
    end
  end

  // R4: after a tick the prescaler restarts from zero
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel import ivt_pkg::*; #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned MAX_SHIFT = 4,
  parameter int unsigned DIV_BASE  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grp_tick,
  input  logic [MAX_SHIFT-1:0] grp_phase,
  input  logic [SEL_W-1:0]     sel,
  input  ctl_t                 ctl,
  input  logic [CNT_W-1:0]     cnt_buf,
  input  logic [CNT_W-1:0]     cmp_buf,
  output logic [CNT_W-1:0]     cnt_q,
  output logic                 expire,
  output logic                 flag
);

  localparam int unsigned SUM_W = SEL_W + 1;

  logic [SUM_W-1:0]     shift_raw;
  logic [MAX_SHIFT-1:0] mask;
  logic                 tick;
  logic                 run;
  logic                 ld_en;
  logic [CNT_W-1:0]     cnt_n;
  logic [CNT_W-1:0]     cmp_q;
  logic [CNT_W-1:0]     cmp_n;

  always_comb begin
    shift_raw = SUM_W'(sel) + SUM_W'(DIV_BASE);
    for (int i = 0; i < MAX_SHIFT; i++) begin
      mask[i] = (32'(i) < 32'(shift_raw));
    end
    tick   = grp_tick && ((grp_phase & mask) == mask);
    run    = ctl.start && !ctl.manual && tick;
    expire = run && (cnt_q == CNT_W'(1));
  end

  always_comb begin
    cnt_n = cnt_q;
    cmp_n = cmp_q;
    if (ctl.manual) begin
      cnt_n = cnt_buf;
      cmp_n = cmp_buf;
    end else if (run) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_n = ctl.autorl ? cnt_buf : '0;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
    ld_en = ctl.manual || run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else if (ld_en) begin
      cnt_q <= cnt_n;
      cmp_q <= cmp_n;
    end
  end

  assign flag = (cnt_q <= cmp_q) ^ ctl.inv;

  // R3: manual update copies the count buffer into the counter
  a_r3_manual_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.manual |=> (cnt_q == $past(cnt_buf)));

  // R8: a stopped channel holds its counter
  a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.start && !ctl.manual) |=> $stable(cnt_q));

  // R6: a periodic expiry reloads from the count buffer
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctl.autorl) |=> (cnt_q == $past(cnt_buf)));

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer import ivt_pkg::*; #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PS_W      = 8,
  parameter int unsigned MAX_SHIFT = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq,
  output logic [NCH-1:0]    cmp_flag
);

  localparam int unsigned DIV_BASE = (CNT_W == 16) ? 1 : 0;
  localparam int unsigned PSC_W    = NGRP * PS_W;
  localparam int unsigned DSEL_W   = NCH * SEL_W;
  localparam int unsigned NCMP     = NCH - 1;

  function automatic logic addr_is(logic [ADDR_W-1:0] a, int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // reset: asserted asynchronously, released on the clock
  logic rst_meta;
  logic rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  // register file state
  logic [PSC_W-1:0]  psc_q,  psc_n;
  logic [DSEL_W-1:0] dsel_q, dsel_n;
  ctl_t              ctl_q  [NCH];
  ctl_t              ctl_n  [NCH];
  logic [CNT_W-1:0]  cntb_q [NCH];
  logic [CNT_W-1:0]  cntb_n [NCH];
  logic [CNT_W-1:0]  cmpb_q [NCMP];
  logic [CNT_W-1:0]  cmpb_n [NCMP];
  logic [NCH-1:0]    en_q, en_n, st_q, st_n, st_clr;

  logic [NCH-1:0]    expire;
  logic [CNT_W-1:0]  cnt_obs [NCH];
  logic              wr_ctl, wr_int;

  logic                 grp_tick  [NGRP];
  logic [MAX_SHIFT-1:0] grp_phase [NGRP];

  assign wr_ctl = bus_wr && addr_is(bus_addr, OFS_CTL);
  assign wr_int = bus_wr && addr_is(bus_addr, OFS_INT);

  // next state
  always_comb begin
    psc_n  = psc_q;
    dsel_n = dsel_q;
    if (bus_wr && addr_is(bus_addr, OFS_PSC))  psc_n  = bus_wdata[PSC_W-1:0];
    if (bus_wr && addr_is(bus_addr, OFS_DSEL)) dsel_n = bus_wdata[DSEL_W-1:0];

    for (int n = 0; n < NCH; n++) begin
      ctl_n[n] = ctl_q[n];
      if (wr_ctl) begin
        ctl_n[n] = ctl_t'(bus_wdata[ctl_lsb(n) +: NIB]);
      end else if (expire[n] && !ctl_q[n].autorl) begin
        ctl_n[n].start = 1'b0;
      end
      cntb_n[n] = cntb_q[n];
      if (bus_wr && addr_is(bus_addr, ofs_cntb(n))) cntb_n[n] = bus_wdata[CNT_W-1:0];
    end

    for (int n = 0; n < NCMP; n++) begin
      cmpb_n[n] = cmpb_q[n];
      if (bus_wr && addr_is(bus_addr, ofs_cmpb(n))) cmpb_n[n] = bus_wdata[CNT_W-1:0];
    end

    en_n   = wr_int ? bus_wdata[NCH-1:0] : en_q;
    st_clr = wr_int ? bus_wdata[2*NCH-1:NCH] : '0;
    st_n   = (st_q & ~st_clr) | expire;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      psc_q  <= '0;
      dsel_q <= '0;
      en_q   <= '0;
      st_q   <= '0;
      for (int n = 0; n < NCH; n++) begin
        ctl_q[n]  <= '0;
        cntb_q[n] <= '0;
      end
      for (int n = 0; n < NCMP; n++) begin
        cmpb_q[n] <= '0;
      end
    end else begin
      psc_q  <= psc_n;
      dsel_q <= dsel_n;
      en_q   <= en_n;
      st_q   <= st_n;
      for (int n = 0; n < NCH; n++) begin
        ctl_q[n]  <= ctl_n[n];
        cntb_q[n] <= cntb_n[n];
      end
      for (int n = 0; n < NCMP; n++) begin
        cmpb_q[n] <= cmpb_n[n];
      end
    end
  end

  // shared prescalers
  for (genvar g = 0; g < NGRP; g++) begin : g_psc
    ivt_prescale #(
      .PS_W      (PS_W),
      .MAX_SHIFT (MAX_SHIFT)
    ) u_psc (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .div_val (psc_q[g*PS_W +: PS_W]),
      .tick    (grp_tick[g]),
      .phase   (grp_phase[g])
    );
  end

  // channels
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int unsigned GRP = grp_of(n);
    logic [CNT_W-1:0] cmp_src;

    if (n < NCMP) begin : g_cmp
      assign cmp_src = cmpb_q[n];
    end else begin : g_nocmp
      assign cmp_src = '0;
    end

    ivt_channel #(
      .CNT_W     (CNT_W),
      .MAX_SHIFT (MAX_SHIFT),
      .DIV_BASE  (DIV_BASE)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .grp_tick  (grp_tick[GRP]),
      .grp_phase (grp_phase[GRP]),
      .sel       (dsel_q[n*SEL_W +: SEL_W]),
      .ctl       (ctl_q[n]),
      .cnt_buf   (cntb_q[n]),
      .cmp_buf   (cmp_src),
      .cnt_q     (cnt_obs[n]),
      .expire    (expire[n]),
      .flag      (cmp_flag[n])
    );

    // R10: an expiry always leaves its pending bit set
    a_r10_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n_i)
      expire[n] |=> st_q[n]);

    // R9: write-1-clear without a competing expiry empties the bit
    a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n_i)
      (wr_int && bus_wdata[NCH+n] && !expire[n]) |=> !st_q[n]);

    // R5: a one-shot expiry drops start
    a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n_i)
      (expire[n] && !ctl_q[n].autorl && !wr_ctl) |=> !ctl_q[n].start);
  end

  assign irq = st_q & en_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (addr_is(bus_addr, OFS_PSC))  bus_rdata[PSC_W-1:0]  = psc_q;
    if (addr_is(bus_addr, OFS_DSEL)) bus_rdata[DSEL_W-1:0] = dsel_q;
    if (addr_is(bus_addr, OFS_INT))  bus_rdata[2*NCH-1:0]  = {st_q, en_q};
    for (int n = 0; n < NCH; n++) begin
      if (addr_is(bus_addr, OFS_CTL))     bus_rdata[ctl_lsb(n) +: NIB] = ctl_q[n];
      if (addr_is(bus_addr, ofs_cntb(n))) bus_rdata[CNT_W-1:0] = cntb_q[n];
      if (addr_is(bus_addr, ofs_obs(n)))  bus_rdata[CNT_W-1:0] = cnt_obs[n];
    end
    for (int n = 0; n < NCMP; n++) begin
      if (addr_is(bus_addr, ofs_cmpb(n))) bus_rdata[CNT_W-1:0] = cmpb_q[n];
    end
  end

endmodule

// File: tb/ivt_timer_test.sv
module ivt_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  irq;
  logic [4:0]  cmp_flag;

  always #4 clk = ~clk;

  ivt_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .cmp_flag  (cmp_flag)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { int ch; int at; string req; } evt_t;
  evt_t exp_q[$];

  task automatic check_eq(string req, string what, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; the write lands on edge cyc+1
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_edge(int e);
    while (cyc + 1 < e) @(negedge clk);
  endtask

  // scoreboard monitor
  logic [4:0] irq_prev = '0;
  evt_t       mon_e;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int n = 0; n < 5; n++) begin
        if (irq[n] === 1'b1 && irq_prev[n] === 1'b0) begin
          if (exp_q.size() == 0) begin
            check_eq("R9", "unexpected irq channel", n, 99);
          end else begin
            mon_e = exp_q.pop_front();
            check_eq(mon_e.req, "irq channel", n, mon_e.ch);
            check_eq(mon_e.req, "irq edge", cyc, mon_e.at);
          end
        end
      end
      irq_prev <= irq;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1: run did not finish, actual cycle %0d expected fewer", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] rd, rd2;
    int ws, ws2, ws3, ws4, t1, t2, expv;

    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    bus_read(8'h00, rd); check_eq("R1", "prescaler reg", rd, 0);
    bus_read(8'h08, rd); check_eq("R1", "control reg", rd, 0);
    bus_read(8'h44, rd); check_eq("R1", "interrupt reg", rd, 0);
    bus_read(8'h14, rd); check_eq("R1", "ch0 counter", rd, 0);
    check_eq("R1", "irq", irq, 0);
    check_eq("R1", "cmp_flag", cmp_flag, 5'h1f);

    // R2 offsets, masks, ignored writes
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, rd); check_eq("R2", "prescaler mask", rd, 32'h0000_FFFF);
    bus_write(8'h00, 32'h0);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, rd); check_eq("R2", "divider select mask", rd, 32'h000F_FFFF);
    bus_write(8'h04, 32'h0);
    bus_write(8'h08, 32'h0000_00F0);
    bus_read(8'h08, rd); check_eq("R2", "control bits 7:4 ignored", rd, 0);
    bus_write(8'h3C, 32'h1234);
    bus_read(8'h3C, rd); check_eq("R2", "ch4 count buffer", rd, 32'h1234);
    bus_write(8'h40, 32'h55);
    bus_read(8'h40, rd); check_eq("R2", "ch4 counter write ignored", rd, 0);

    // R11 channel 4 compares against zero
    bus_write(8'h08, 32'h0020_0000);
    idle(2);
    check_eq("R11", "ch4 flag", cmp_flag[4], 0);
    bus_read(8'h40, rd); check_eq("R3", "ch4 counter loaded", rd, 32'h1234);
    bus_write(8'h08, 32'h0);

    // R3 manual update, R11 compare flag
    bus_write(8'h0C, 10);
    bus_write(8'h10, 4);
    bus_write(8'h08, 32'h2);
    idle(1);
    bus_read(8'h14, rd); check_eq("R3", "ch0 loaded", rd, 10);
    check_eq("R11", "ch0 flag 10 vs 4", cmp_flag[0], 0);
    idle(5);
    bus_read(8'h14, rd); check_eq("R3", "no count while manual", rd, 10);
    bus_write(8'h08, 32'h6);
    idle(1);
    check_eq("R11", "ch0 flag inverted", cmp_flag[0], 1);

    // R5 one-shot
    bus_write(8'h44, 32'h01);
    bus_write(8'h0C, 5);
    bus_write(8'h08, 32'h2);
    idle(1);
    ws = cyc + 1;
    exp_q.push_back('{0, ws + 5, "R5"});
    bus_write(8'h08, 32'h1);
    idle(10);
    bus_read(8'h08, rd); check_eq("R5", "start cleared", rd, 0);
    bus_read(8'h14, rd); check_eq("R5", "counter stays 0", rd, 0);
    bus_read(8'h44, rd); check_eq("R9", "pending ch0", rd, 32'h21);
    bus_write(8'h44, 32'h21);
    bus_read(8'h44, rd); check_eq("R9", "cleared ch0", rd, 32'h01);
    check_eq("R9", "irq0 low", irq[0], 0);

    // R8 freeze and resume, reads without side effects
    bus_write(8'h18, 100);
    bus_write(8'h08, 32'h200);
    idle(1);
    ws = cyc + 1;
    bus_write(8'h08, 32'h100);
    idle(9);
    ws2 = cyc + 1;
    bus_write(8'h08, 32'h0);
    expv = 100 - (ws2 - ws);
    bus_read(8'h20, rd);
    bus_read(8'h20, rd2);
    check_eq("R8", "frozen value", rd, expv);
    check_eq("R8", "second read", rd2, expv);
    idle(5);
    bus_read(8'h20, rd); check_eq("R8", "still frozen", rd, expv);
    ws3 = cyc + 1;
    bus_write(8'h08, 32'h100);
    idle(3);
    ws4 = cyc + 1;
    bus_write(8'h08, 32'h0);
    expv = expv - (ws4 - ws3);
    bus_read(8'h20, rd); check_eq("R8", "resumed value", rd, expv);

    // R6 periodic on channel 2
    bus_write(8'h44, 32'h05);
    bus_write(8'h24, 5);
    bus_write(8'h08, 32'h2000);
    idle(1);
    ws = cyc + 1;
    exp_q.push_back('{2, ws + 5, "R6"});
    exp_q.push_back('{2, ws + 10, "R6"});
    exp_q.push_back('{2, ws + 15, "R6"});
    bus_write(8'h08, 32'h9000);
    wait_edge(ws + 7);
    bus_write(8'h44, 32'h85);
    wait_edge(ws + 12);
    bus_write(8'h44, 32'h85);
    wait_edge(ws + 17);
    bus_write(8'h08, 32'h0);
    bus_read(8'h2C, rd); check_eq("R6", "reloaded counter", rd, 3);
    bus_write(8'h44, 32'h85);
    bus_read(8'h44, rd); check_eq("R9", "ch2 cleared", rd, 32'h05);

    // R9 pending without enable on channel 3
    bus_write(8'h30, 2);
    bus_write(8'h08, 32'h2_0000);
    idle(1);
    bus_write(8'h08, 32'h1_0000);
    idle(6);
    bus_read(8'h44, rd); check_eq("R9", "ch3 pending, disabled", rd, 32'h105);
    check_eq("R9", "irq3 stays low", irq[3], 0);
    bus_write(8'h44, 32'h105);
    bus_read(8'h44, rd); check_eq("R9", "ch3 cleared", rd, 32'h05);

    // R10 expiry and clear in the same cycle
    bus_write(8'h0C, 4);
    bus_write(8'h08, 32'h2);
    idle(1);
    ws = cyc + 1;
    exp_q.push_back('{0, ws + 4, "R10"});
    bus_write(8'h08, 32'h1);
    wait_edge(ws + 4);
    bus_write(8'h44, 32'h25);
    bus_read(8'h44, rd); check_eq("R10", "set wins over clear", rd, 32'h25);
    check_eq("R10", "irq0 high", irq[0], 1);
    bus_write(8'h44, 32'h25);
    bus_read(8'h44, rd); check_eq("R10", "later clear", rd, 32'h05);

    // R7 zero load never expires
    bus_write(8'h0C, 0);
    bus_write(8'h08, 32'h2);
    idle(1);
    bus_write(8'h08, 32'h1);
    idle(20);
    bus_read(8'h44, rd); check_eq("R7", "no pending", rd, 32'h05);
    bus_read(8'h08, rd); check_eq("R7", "start kept", rd, 32'h1);
    check_eq("R7", "irq0 low", irq[0], 0);
    bus_write(8'h08, 32'h0);

    // R4 prescaler 1 = 2, ch2 select 1: 3*2 clocks per tick, period 18
    bus_write(8'h44, 32'h0);
    bus_write(8'h00, 32'h0200);
    bus_write(8'h04, 32'h0100);
    bus_write(8'h24, 3);
    bus_write(8'h08, 32'h2000);
    idle(1);
    bus_write(8'h08, 32'h9000);
    rd = 0;
    while (rd[7] == 1'b0) begin idle(1); bus_read(8'h44, rd); end
    t1 = cyc;
    bus_write(8'h44, 32'h80);
    rd = 0;
    while (rd[7] == 1'b0) begin idle(1); bus_read(8'h44, rd); end
    t2 = cyc;
    check_eq("R4", "tick period", t2 - t1, 18);
    bus_write(8'h08, 32'h0);
    bus_write(8'h44, 32'h80);

    idle(2);
    check_eq("R5", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule